// File: doc/BRIEF.md
# Core idle-state resolution controller

This block sits beside one multithreaded core. Each hardware thread presents its own idle-level request code, and the threads choose their levels independently. The core stays running while any thread asks to run. Once every thread asks for some idle level, the block picks the shallowest of those levels and latches it. It then takes the core down through a fixed series of steps: cache flush, state save, clock gating and then a voltage change. Which steps run depends on the level.

A wake event, or any thread returning to the run code, brings the core back. The steps are undone in reverse order: the voltage returns to nominal, the clocks are ungated, and saved state is restored. A one-cycle wake-complete pulse follows once an exit-latency counter has run out. The short count applies to the shallow levels and the long count to the deep levels. If a wake arrives while entry is still in progress, the entry is unwound from the step it had reached.

The flush engine, the voltage regulator and the state store live outside the block and are reached through req/ack handshakes. A cluster-level deep indication is raised while this core and every peer core report a deep level.

Top module: `core_idle_ctrl`

## Requirements
- R1: After the synchronous active-high reset, the core is reported running: core_state = 0, clocks ungated, voltage mode nominal (0), and every request output and wake_done low.
- R2: While any thread request is 0 (run), the block starts no entry: flush_req, save_req, volt_req and clk_gate stay low.
- R3: Request codes are 0 run, 1 light, 2 light-scaled, 3 retention, 6 power-off. Codes 4, 5 and 7 count as 1. When all threads request idle, the level is the numerically smallest normalised code. While idle, core_state shows that code; at all other times it shows 0.
- R4: Each level has its own set of actions:
  - Level 1 gates the clocks at nominal voltage (mode 0).
  - Level 2 gates the clocks with scaled voltage (mode 1).
  - Level 3 flushes the caches without the TLB (flush_tlb = 0), gates the core and snoop clocks, and uses retention voltage (mode 2).
  - Level 6 flushes the caches and the TLB (flush_tlb = 1), saves state, gates the core and snoop clocks, and switches the supply off (mode 3).
  - The voltage mode is non-nominal only while the clocks are gated.
- R5: Entry runs flush, then save, then clock gate, then voltage change. Each request is held until its ack is sampled, and at most one of the handshake requests is high at any time.
- R6: Exit runs a volt_req back to nominal (skipped for level 1), then ungating, then restore_req (level 6 only, after a completed entry). wake_done follows after that.
- R7: wake_done is a single-cycle pulse. It comes no earlier than SHORT_EXIT_CYC cycles (levels 1 and 2) or LONG_EXIT_CYC cycles (levels 3 and 6) after the exit began, and it waits for the restore ack.
- R8: A wake, or a thread request of 0, while flush or save is pending returns the core to running with no wake_done. During the voltage-down step, the same events unwind through the exit path: wake_done is produced and no restore is requested.
- R9: pkg_deep is high exactly while this core is idle at level 3 or 6 and every peer_deep bit is high.
- R10: An idle core leaves idle when wake is high or any thread request returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_req | input | 3*NUM_THREADS | Per-thread level request codes, thread 0 in the low bits |
| wake | input | 1 | Wake event |
| peer_deep | input | NUM_PEERS | Deep-level flags from the other cores of the cluster |
| flush_ack | input | 1 | Flush engine acknowledge |
| save_ack | input | 1 | State store save acknowledge |
| volt_ack | input | 1 | Regulator acknowledge |
| restore_ack | input | 1 | State store restore acknowledge |
| core_state | output | 3 | Resolved core level while idle, 0 otherwise |
| clk_gate | output | 1 | Core clock gate enable |
| snoop_gate | output | 1 | Snoop/coherence clock gate enable |
| volt_mode | output | 2 | 0 nominal, 1 scaled, 2 retention, 3 off |
| volt_req | output | 1 | Regulator request for volt_mode |
| flush_req | output | 1 | Cache flush request |
| flush_tlb | output | 1 | Flush also covers the TLB |
| save_req | output | 1 | State save request |
| restore_req | output | 1 | State restore request |
| wake_done | output | 1 | One-cycle exit-complete pulse |
| pkg_deep | output | 1 | Whole cluster is in a deep level |

## Verification
The hardest cases to reach from the ports are the entry aborts, because they need a wake or a cancel that lands while a particular handshake is still outstanding. The bench's ack responder has a separate delay for each channel. Stretching the flush delay or the regulator delay holds the controller in that step long enough to drop a thread request or raise wake there. A behavioural model compares every output on every clock, so the ordering of the unwind and the timing of the exit latency are both checked.

// File: rtl/cidle_pkg.sv
package cidle_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] lvl_t;

  localparam lvl_t LVL_RUN = 3'd0;
  localparam lvl_t LVL_1   = 3'd1;
  localparam lvl_t LVL_1S  = 3'd2;
  localparam lvl_t LVL_3   = 3'd3;
  localparam lvl_t LVL_6   = 3'd6;

  typedef enum logic [1:0] {
    VM_NOM    = 2'd0,
    VM_SCALED = 2'd1,
    VM_RET    = 2'd2,
    VM_OFF    = 2'd3
  } vmode_t;

  typedef enum logic [3:0] {
    ST_RUN, ST_FLUSH, ST_SAVE, ST_GATE, ST_VDN,
    ST_IDLE, ST_VUP, ST_UNGATE, ST_RESTORE, ST_SETTLE
  } seq_t;

  function automatic lvl_t norm_lvl(input lvl_t code);
    case (code)
      LVL_RUN, LVL_1, LVL_1S, LVL_3, LVL_6: norm_lvl = code;
      default:                              norm_lvl = LVL_1;
    endcase
  endfunction

  function automatic vmode_t lvl_vmode(input lvl_t l);
    case (l)
      LVL_1S:  lvl_vmode = VM_SCALED;
      LVL_3:   lvl_vmode = VM_RET;
      LVL_6:   lvl_vmode = VM_OFF;
      default: lvl_vmode = VM_NOM;
    endcase
  endfunction

  function automatic logic lvl_deep(input lvl_t l);
    lvl_deep = (l == LVL_3) || (l == LVL_6);
  endfunction
endpackage

// File: rtl/cidle_resolve.sv
module cidle_resolve
  import cidle_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic [NUM_THREADS*CODE_W-1:0] thr_req,
  output logic                          all_idle,
  output logic                          any_run,
  output lvl_t                          shallow
);
  lvl_t                   norm [NUM_THREADS];
  logic [NUM_THREADS-1:0] run_bit;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    assign norm[g]    = norm_lvl(thr_req[g*CODE_W +: CODE_W]);
    assign run_bit[g] = (norm[g] == LVL_RUN);
  end

  assign any_run  = |run_bit;
  assign all_idle = ~any_run;

  always_comb begin
    shallow = LVL_6;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (norm[i] < shallow) shallow = norm[i];
    end
  end
endmodule

// File: rtl/cidle_exit_timer.sv
module cidle_exit_timer #(
  parameter int SHORT_CYC = 250,
  parameter int LONG_CYC  = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic long_sel,
  output logic done
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= long_sel ? CW'(LONG_CYC) : CW'(SHORT_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R7
  timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> done);

  // R7
  timer_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !done);
endmodule

// File: rtl/cidle_seq.sv
module cidle_seq
  import cidle_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       all_idle,
  input  logic       any_run,
  input  lvl_t       shallow,
  input  logic       wake,
  input  logic       flush_ack,
  input  logic       save_ack,
  input  logic       volt_ack,
  input  logic       restore_ack,
  input  logic       timer_done,
  output logic       timer_load,
  output logic       timer_long,
  output logic [2:0] core_state,
  output logic       clk_gate,
  output logic       snoop_gate,
  output logic [1:0] volt_mode,
  output logic       volt_req,
  output logic       flush_req,
  output logic       flush_tlb,
  output logic       save_req,
  output logic       restore_req,
  output logic       wake_done,
  output logic       own_deep
);
  seq_t st_q, st_d;
  lvl_t lvl_q, lvl_d;
  logic entered_q, entered_d;
  logic done_d;
  logic abort;

  assign abort = wake | any_run;

  always_comb begin
    st_d       = st_q;
    lvl_d      = lvl_q;
    entered_d  = entered_q;
    timer_load = 1'b0;
    done_d     = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        entered_d = 1'b0;
        if (all_idle && !wake) begin
          lvl_d = shallow;
          st_d  = lvl_deep(shallow) ? ST_FLUSH : ST_GATE;
        end
      end
      ST_FLUSH: begin
        if (abort)          st_d = ST_RUN;
        else if (flush_ack) st_d = (lvl_q == LVL_6) ? ST_SAVE : ST_GATE;
      end
      ST_SAVE: begin
        if (abort)         st_d = ST_RUN;
        else if (save_ack) st_d = ST_GATE;
      end
      ST_GATE: begin
        if (lvl_q == LVL_1) begin
          st_d      = ST_IDLE;
          entered_d = 1'b1;
        end else begin
          st_d = ST_VDN;
        end
      end
      ST_VDN: begin
        if (abort) begin
          st_d       = ST_VUP;
          timer_load = 1'b1;
        end else if (volt_ack) begin
          st_d      = ST_IDLE;
          entered_d = 1'b1;
        end
      end
      ST_IDLE: begin
        if (abort) begin
          timer_load = 1'b1;
          st_d       = (lvl_q == LVL_1) ? ST_UNGATE : ST_VUP;
        end
      end
      ST_VUP: begin
        if (volt_ack) st_d = ST_UNGATE;
      end
      ST_UNGATE: begin
        st_d = (lvl_q == LVL_6 && entered_q) ? ST_RESTORE : ST_SETTLE;
      end
      ST_RESTORE: begin
        if (restore_ack) st_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (timer_done) begin
          st_d   = ST_RUN;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_RUN;
      lvl_q     <= LVL_RUN;
      entered_q <= 1'b0;
      wake_done <= 1'b0;
    end else begin
      st_q      <= st_d;
      lvl_q     <= lvl_d;
      entered_q <= entered_d;
      wake_done <= done_d;
    end
  end

  assign timer_long  = lvl_deep(lvl_q);
  assign clk_gate    = (st_q == ST_GATE) || (st_q == ST_VDN) ||
                       (st_q == ST_IDLE) || (st_q == ST_VUP);
  assign snoop_gate  = clk_gate && lvl_deep(lvl_q);
  assign volt_mode   = ((st_q == ST_VDN) || (st_q == ST_IDLE)) ? lvl_vmode(lvl_q) : VM_NOM;
  assign volt_req    = (st_q == ST_VDN) || (st_q == ST_VUP);
  assign flush_req   = (st_q == ST_FLUSH);
  assign flush_tlb   = flush_req && (lvl_q == LVL_6);
  assign save_req    = (st_q == ST_SAVE);
  assign restore_req = (st_q == ST_RESTORE);
  assign core_state  = (st_q == ST_IDLE) ? lvl_q : LVL_RUN;
  assign own_deep    = (st_q == ST_IDLE) && lvl_deep(lvl_q);

  // R5
  hs_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flush_req, save_req, volt_req, restore_req}));

  // R5
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !flush_ack && !wake && !any_run) |=> flush_req);

  // R7
  wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wake_done |=> !wake_done);

  // R4
  volt_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (volt_mode != 2'd0) |-> clk_gate);

  // R6
  restore_ungated_chk: assert property (@(posedge clk) disable iff (rst)
    restore_req |-> !clk_gate);

  // R2
  no_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (core_state == 3'd0 && !clk_gate && !flush_req && any_run) |=> !(flush_req || clk_gate));
endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl
  import cidle_pkg::*;
#(
  parameter int NUM_THREADS    = 2,
  parameter int NUM_PEERS      = 3,
  parameter int SHORT_EXIT_CYC = 250,
  parameter int LONG_EXIT_CYC  = 2500
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_THREADS*CODE_W-1:0] thr_req,
  input  logic                          wake,
  input  logic [NUM_PEERS-1:0]          peer_deep,
  input  logic                          flush_ack,
  input  logic                          save_ack,
  input  logic                          volt_ack,
  input  logic                          restore_ack,
  output logic [2:0]                    core_state,
  output logic                          clk_gate,
  output logic                          snoop_gate,
  output logic [1:0]                    volt_mode,
  output logic                          volt_req,
  output logic                          flush_req,
  output logic                          flush_tlb,
  output logic                          save_req,
  output logic                          restore_req,
  output logic                          wake_done,
  output logic                          pkg_deep
);
  logic all_idle, any_run;
  lvl_t shallow;
  logic t_load, t_long, t_done;
  logic own_deep;

  cidle_resolve #(.NUM_THREADS(NUM_THREADS)) u_resolve (
    .thr_req  (thr_req),
    .all_idle (all_idle),
    .any_run  (any_run),
    .shallow  (shallow)
  );

  cidle_exit_timer #(.SHORT_CYC(SHORT_EXIT_CYC), .LONG_CYC(LONG_EXIT_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .long_sel (t_long),
    .done     (t_done)
  );

  cidle_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .all_idle    (all_idle),
    .any_run     (any_run),
    .shallow     (shallow),
    .wake        (wake),
    .flush_ack   (flush_ack),
    .save_ack    (save_ack),
    .volt_ack    (volt_ack),
    .restore_ack (restore_ack),
    .timer_done  (t_done),
    .timer_load  (t_load),
    .timer_long  (t_long),
    .core_state  (core_state),
    .clk_gate    (clk_gate),
    .snoop_gate  (snoop_gate),
    .volt_mode   (volt_mode),
    .volt_req    (volt_req),
    .flush_req   (flush_req),
    .flush_tlb   (flush_tlb),
    .save_req    (save_req),
    .restore_req (restore_req),
    .wake_done   (wake_done),
    .own_deep    (own_deep)
  );

  assign pkg_deep = own_deep && (&peer_deep);

  // R9
  pkg_own_chk: assert property (@(posedge clk) disable iff (rst)
    pkg_deep |-> (core_state == 3'd3 || core_state == 3'd6));
endmodule

// File: tb/core_idle_ctrl_tb.sv
module core_idle_ctrl_tb;
  localparam int NT = 2;
  localparam int NP = 3;
  localparam int SHORT = 12;
  localparam int LONG = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT*3-1:0] thr_req = '0;
  logic wake = 1'b0;
  logic [NP-1:0] peer_deep = '0;
  logic flush_ack = 1'b0, save_ack = 1'b0, volt_ack = 1'b0, restore_ack = 1'b0;
  logic [2:0] core_state;
  logic clk_gate, snoop_gate, volt_req, flush_req, flush_tlb, save_req, restore_req;
  logic wake_done, pkg_deep;
  logic [1:0] volt_mode;

  always #2 clk = ~clk;

  core_idle_ctrl #(.NUM_THREADS(NT), .NUM_PEERS(NP),
                   .SHORT_EXIT_CYC(SHORT), .LONG_EXIT_CYC(LONG)) u_dut (
    .clk(clk), .rst(rst), .thr_req(thr_req), .wake(wake), .peer_deep(peer_deep),
    .flush_ack(flush_ack), .save_ack(save_ack), .volt_ack(volt_ack),
    .restore_ack(restore_ack), .core_state(core_state), .clk_gate(clk_gate),
    .snoop_gate(snoop_gate), .volt_mode(volt_mode), .volt_req(volt_req),
    .flush_req(flush_req), .flush_tlb(flush_tlb), .save_req(save_req),
    .restore_req(restore_req), .wake_done(wake_done), .pkg_deep(pkg_deep)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ack responder with per-channel delay
  int f_dly = 3, s_dly = 3, v_dly = 2, r_dly = 3;
  int fc = 0, sc = 0, vc = 0, rc = 0;
  always @(posedge clk) begin
    #1;
    if (flush_req) begin
      if (fc >= f_dly) begin flush_ack = 1; fc = 0; end else begin flush_ack = 0; fc++; end
    end else begin flush_ack = 0; fc = 0; end
    if (save_req) begin
      if (sc >= s_dly) begin save_ack = 1; sc = 0; end else begin save_ack = 0; sc++; end
    end else begin save_ack = 0; sc = 0; end
    if (volt_req) begin
      if (vc >= v_dly) begin volt_ack = 1; vc = 0; end else begin volt_ack = 0; vc++; end
    end else begin volt_ack = 0; vc = 0; end
    if (restore_req) begin
      if (rc >= r_dly) begin restore_ack = 1; rc = 0; end else begin restore_ack = 0; rc++; end
    end else begin restore_ack = 0; rc = 0; end
  end

  // behavioural reference model
  localparam int M_RUN = 0, M_FL = 1, M_SV = 2, M_GT = 3, M_DN = 4, M_ID = 5,
                 M_UP = 6, M_UG = 7, M_RS = 8, M_WT = 9;
  int m_ph = M_RUN, m_lvl = 0, m_t0 = 0, ecyc = 0;
  bit m_ent = 0, m_pulse = 0;

  function automatic int code_of(input int c);
    return (c == 0 || c == 1 || c == 2 || c == 3 || c == 6) ? c : 1;
  endfunction
  function automatic bit is_deep(input int l);
    return l == 3 || l == 6;
  endfunction
  function automatic int mode_of(input int l);
    return (l == 2) ? 1 : (l == 3) ? 2 : (l == 6) ? 3 : 0;
  endfunction

  always @(posedge clk) begin
    int a, b, lo;
    bit stop, idle;
    ecyc++;
    a = code_of(int'(thr_req[2:0]));
    b = code_of(int'(thr_req[5:3]));
    idle = (a != 0) && (b != 0);
    lo = (a < b) ? a : b;
    stop = wake || !idle;
    if (rst) begin
      m_ph = M_RUN; m_lvl = 0; m_ent = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      case (m_ph)
        M_RUN: begin
          m_ent = 0;
          if (idle && !wake) begin m_lvl = lo; m_ph = is_deep(lo) ? M_FL : M_GT; end
        end
        M_FL: if (stop) m_ph = M_RUN; else if (flush_ack) m_ph = (m_lvl == 6) ? M_SV : M_GT;
        M_SV: if (stop) m_ph = M_RUN; else if (save_ack) m_ph = M_GT;
        M_GT: if (m_lvl == 1) begin m_ph = M_ID; m_ent = 1; end else m_ph = M_DN;
        M_DN: if (stop) begin m_ph = M_UP; m_t0 = ecyc; end
              else if (volt_ack) begin m_ph = M_ID; m_ent = 1; end
        M_ID: if (stop) begin m_t0 = ecyc; m_ph = (m_lvl == 1) ? M_UG : M_UP; end
        M_UP: if (volt_ack) m_ph = M_UG;
        M_UG: m_ph = (m_lvl == 6 && m_ent) ? M_RS : M_WT;
        M_RS: if (restore_ack) m_ph = M_WT;
        M_WT: if ((ecyc - 1 - m_t0) >= (is_deep(m_lvl) ? LONG : SHORT)) begin
                m_ph = M_RUN; m_pulse = 1;
              end
        default: m_ph = M_RUN;
      endcase
    end
  end

  // per-cycle compare and event monitor
  int ncyc = 0;
  int t_mark = 0, t_flush = -1, t_save = -1, t_vreq = -1, t_goff = -1, t_rest = -1, t_wd = -1;
  int n_wd = 0, n_rest = 0, n_save = 0;
  bit saw_tlb = 0, saw_flush = 0;

  task automatic mark();
    t_mark = ncyc; t_flush = -1; t_save = -1; t_vreq = -1; t_goff = -1; t_rest = -1;
    t_wd = -1; n_wd = 0; n_rest = 0; n_save = 0; saw_tlb = 0; saw_flush = 0;
  endtask

  always @(negedge clk) begin
    bit g;
    ncyc++;
    if (!rst) begin
      g = (m_ph == M_GT) || (m_ph == M_DN) || (m_ph == M_ID) || (m_ph == M_UP);
      chk(core_state == ((m_ph == M_ID) ? m_lvl : 0), "R3 core_state", core_state, (m_ph == M_ID) ? m_lvl : 0);
      chk(clk_gate == g, "R4 clk_gate", clk_gate, g);
      chk(snoop_gate == (g && is_deep(m_lvl)), "R4 snoop_gate", snoop_gate, g && is_deep(m_lvl));
      chk(volt_mode == ((m_ph == M_DN || m_ph == M_ID) ? mode_of(m_lvl) : 0), "R4 volt_mode",
          volt_mode, (m_ph == M_DN || m_ph == M_ID) ? mode_of(m_lvl) : 0);
      chk(volt_req == (m_ph == M_DN || m_ph == M_UP), "R5 volt_req", volt_req, m_ph == M_DN || m_ph == M_UP);
      chk(flush_req == (m_ph == M_FL), "R5 flush_req", flush_req, m_ph == M_FL);
      chk(flush_tlb == (m_ph == M_FL && m_lvl == 6), "R4 flush_tlb", flush_tlb, m_ph == M_FL && m_lvl == 6);
      chk(save_req == (m_ph == M_SV), "R5 save_req", save_req, m_ph == M_SV);
      chk(restore_req == (m_ph == M_RS), "R6 restore_req", restore_req, m_ph == M_RS);
      chk(wake_done == m_pulse, "R7 wake_done", wake_done, m_pulse);
      chk(pkg_deep == (m_ph == M_ID && is_deep(m_lvl) && (&peer_deep)), "R9 pkg_deep",
          pkg_deep, m_ph == M_ID && is_deep(m_lvl) && (&peer_deep));
    end
    if (flush_req) begin saw_flush = 1; if (flush_tlb) saw_tlb = 1; if (t_flush < 0) t_flush = ncyc; end
    if (save_req) begin n_save++; if (t_save < 0) t_save = ncyc; end
    if (volt_req && t_vreq < 0) t_vreq = ncyc;
    if (!clk_gate && t_goff < 0) t_goff = ncyc;
    if (restore_req) begin n_rest++; if (t_rest < 0) t_rest = ncyc; end
    if (wake_done) begin n_wd++; if (t_wd < 0) t_wd = ncyc; end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic set_thr(input int a, input int b);
    thr_req = {3'(b), 3'(a)};
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL R7 watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk(core_state == 0 && !clk_gate && volt_mode == 0 && !wake_done, "R1 reset outputs", core_state, 0);
    chk(!flush_req && !save_req && !volt_req && !restore_req, "R1 reset requests", flush_req, 0);

    // R2 one thread still running
    set_thr(1, 0);
    step(15);
    chk(!clk_gate && !flush_req && !volt_req, "R2 no entry with running thread", clk_gate, 0);

    // R3 R4 light-scaled, exit by wake (R10)
    set_thr(2, 6);
    step(10);
    chk(core_state == 2, "R3 shallowest of 2,6", core_state, 2);
    chk(volt_mode == 1 && clk_gate && !snoop_gate, "R4 scaled level actions", volt_mode, 1);
    mark();
    wake = 1'b1;
    step(50);
    chk(n_wd == 1, "R10 wake leaves idle", n_wd, 1);
    chk(t_wd - t_mark >= SHORT, "R7 short exit latency", t_wd - t_mark, SHORT);
    chk(n_rest == 0, "R6 no restore for shallow level", n_rest, 0);
    set_thr(0, 0);
    wake = 1'b0;
    step(2);

    // R5 R4 power-off level entry order
    mark();
    set_thr(6, 6);
    step(40);
    chk(core_state == 6, "R3 level 6 resolved", core_state, 6);
    chk(volt_mode == 3 && snoop_gate, "R4 power-off actions", volt_mode, 3);
    chk(saw_tlb, "R4 tlb flush for level 6", saw_tlb, 1);
    chk(t_flush > 0 && t_flush < t_save && t_save < t_vreq, "R5 flush then save then voltage", t_save, t_flush + 1);
    // R6 exit by thread cancel (R10)
    mark();
    set_thr(6, 0);
    step(80);
    chk(t_vreq > 0 && t_vreq < t_goff && t_goff < t_rest && t_rest < t_wd, "R6 exit order", t_rest, t_goff + 1);
    chk(n_wd == 1, "R10 cancel leaves idle", n_wd, 1);
    chk(t_wd - t_mark >= LONG, "R7 long exit latency", t_wd - t_mark, LONG);
    set_thr(0, 0);
    step(2);

    // R4 R9 retention level and cluster flag
    mark();
    set_thr(3, 6);
    step(30);
    chk(core_state == 3 && volt_mode == 2, "R4 retention level", volt_mode, 2);
    chk(saw_flush && !saw_tlb && n_save == 0, "R4 retention flush without tlb or save", saw_tlb, 0);
    peer_deep = '1;
    step(1);
    chk(pkg_deep, "R9 cluster deep set", pkg_deep, 1);
    peer_deep = 3'b101;
    step(1);
    chk(!pkg_deep, "R9 one peer shallow", pkg_deep, 0);
    peer_deep = '1;
    set_thr(0, 0);
    step(70);
    chk(!pkg_deep, "R9 cleared after exit", pkg_deep, 0);

    // R3 odd codes map to level 1
    set_thr(5, 7);
    step(8);
    chk(core_state == 1 && clk_gate && volt_mode == 0, "R3 codes 5,7 as level 1", core_state, 1);
    set_thr(0, 0);
    step(30);
    set_thr(7, 2);
    step(8);
    chk(core_state == 1, "R3 code 7 shallower than 2", core_state, 1);
    set_thr(0, 0);
    step(30);

    // R8 abort while flush pending
    f_dly = 30;
    mark();
    set_thr(3, 3);
    step(4);
    chk(flush_req, "R8 flush pending", flush_req, 1);
    wake = 1'b1;
    step(2);
    chk(!flush_req && !clk_gate, "R8 flush abort back to run", flush_req, 0);
    step(20);
    chk(n_wd == 0, "R8 no wake pulse on early abort", n_wd, 0);
    wake = 1'b0;
    set_thr(0, 0);
    f_dly = 3;
    step(2);

    // R8 abort during voltage-down step
    v_dly = 30;
    set_thr(6, 6);
    step(16);
    chk(volt_req && clk_gate && volt_mode == 3, "R8 held in voltage step", volt_mode, 3);
    mark();
    set_thr(0, 6);
    step(90);
    chk(n_wd == 1 && n_rest == 0, "R8 unwind pulses without restore", n_rest, 0);
    v_dly = 2;
    step(4);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule